// File: doc/BRIEF.md
# Isochronous IN Endpoint Frame-Timed Request Unit

This unit produces service requests for a group of isochronous IN endpoints inside a USB device controller. Requests follow the recovered frame tick and ignore host IN tokens. On every tick, each endpoint in DMA mode raises its request bit and refreshes its buffer. The host may not have asked for data yet, so data it never collected is simply overwritten by the next frame's data.

A raised request is edge-triggered. At the moment of raising, the unit looks at the descriptor-valid flag from the descriptor fetch logic. If the descriptor is usable, a start strobe goes to the transfer engine, and the request bit stays high until that engine reports completion. If the descriptor is not usable, nothing starts and the bit stays latched. Software must then clear the bit through the clear port before a later tick can fire it again. All endpoints are evaluated in parallel, every cycle.

Top module: `iso_dma_req`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, req_stat, start_xfer and buf_refresh are all zero.
- R2: An endpoint is in DMA mode when its int_en bit is 0. A frame_tick raises req_stat for such an endpoint one cycle later, with no need for any host request. An endpoint whose int_en bit is 1 is never raised.
- R3: If, at the raising tick, desc_valid or dma_en for that endpoint is 0, no start_xfer fires. req_stat stays 1 through later ticks and through xfer_done pulses.
- R4: A frame_tick on an endpoint whose req_stat is already 1 (with no clear that cycle) does not re-raise it. No start_xfer fires, even if a descriptor is now valid.
- R5: When a raise finds both dma_en and desc_valid set, start_xfer pulses for exactly one cycle, one cycle after the tick. req_stat stays 1 until xfer_done for that endpoint, and drops one cycle after it.
- R6: When clr_wr is 1, each endpoint whose clr_data bit is 1 has its req_stat cleared one cycle later. clr_data bits that are 0, and any clr_data while clr_wr is 0, have no effect.
- R7: If a clear and a frame_tick hit the same DMA-mode endpoint in one cycle, req_stat ends up 1 and the raise is treated as new. This includes the descriptor check and a possible start_xfer.
- R8: buf_refresh pulses one cycle after every frame_tick for each DMA-mode endpoint, whatever the state of req_stat.
- R9: Each endpoint bit position acts on its own bit of every vector. Events on one endpoint do not change another endpoint's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle recovered frame timing pulse |
| int_en | input | NUM_EP | Per-endpoint interrupt mode; 0 selects DMA mode |
| dma_en | input | NUM_EP | Per-endpoint DMA engine enable |
| desc_valid | input | NUM_EP | Per-endpoint descriptor ready flag |
| xfer_done | input | NUM_EP | Per-endpoint transfer completion pulse |
| clr_wr | input | 1 | Write strobe for the clear port |
| clr_data | input | NUM_EP | Clear data; a 1 clears that endpoint's request |
| req_stat | output | NUM_EP | Per-endpoint request status |
| start_xfer | output | NUM_EP | One-cycle start pulse to the transfer engine |
| buf_refresh | output | NUM_EP | One-cycle buffer reload pulse per frame |

## Verification
Each output is a register fed directly from the inputs. req_stat, start_xfer and buf_refresh are therefore all due exactly one rising edge after the cycle in which the tick, clear or completion was presented. The bench presents each stimulus on a falling edge, lets one rising edge pass, and compares all three vectors at the next falling edge, before the next stimulus goes in. A single-cycle pulse is therefore seen in exactly one comparison. Latched and unaffected bits are checked in the rows that follow the stimulus that could have disturbed them.

// File: rtl/iso_dma_req.sv
module iso_dma_req #(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [NUM_EP-1:0] int_en,
  input  logic [NUM_EP-1:0] dma_en,
  input  logic [NUM_EP-1:0] desc_valid,
  input  logic [NUM_EP-1:0] xfer_done,
  input  logic              clr_wr,
  input  logic [NUM_EP-1:0] clr_data,
  output logic [NUM_EP-1:0] req_stat,
  output logic [NUM_EP-1:0] start_xfer,
  output logic [NUM_EP-1:0] buf_refresh
);

  logic [NUM_EP-1:0] req_q, busy_q, start_q, refr_q;

  wire [NUM_EP-1:0] dma_mode = ~int_en;
  wire [NUM_EP-1:0] tick_v   = {NUM_EP{frame_tick}} & dma_mode;
  wire [NUM_EP-1:0] clr_hit  = {NUM_EP{clr_wr}} & clr_data;
  wire [NUM_EP-1:0] raise    = tick_v & (~req_q | clr_hit);
  wire [NUM_EP-1:0] go       = raise & dma_en & desc_valid;
  wire [NUM_EP-1:0] done_hit = xfer_done & busy_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]   <= 1'b0;
        busy_q[i]  <= 1'b0;
        start_q[i] <= 1'b0;
        refr_q[i]  <= 1'b0;
      end else begin
        start_q[i] <= go[i];
        refr_q[i]  <= tick_v[i];
        if (raise[i])
          req_q[i] <= 1'b1;
        else if (clr_hit[i] || done_hit[i])
          req_q[i] <= 1'b0;
        if (go[i])
          busy_q[i] <= 1'b1;
        else if (xfer_done[i])
          busy_q[i] <= 1'b0;
      end
    end
  end

  assign req_stat    = req_q;
  assign start_xfer  = start_q;
  assign buf_refresh = refr_q;

endmodule

// File: rtl/iso_dma_req_chk.sv
module iso_dma_req_chk #(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic [NUM_EP-1:0] int_en,
  input logic [NUM_EP-1:0] xfer_done,
  input logic              clr_wr,
  input logic [NUM_EP-1:0] clr_data,
  input logic [NUM_EP-1:0] req_stat,
  input logic [NUM_EP-1:0] start_xfer,
  input logic [NUM_EP-1:0] buf_refresh
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    a_r2_tick_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !int_en[i]) |=> req_stat[i]);

    a_r3_latched_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stat[i] && !(clr_wr && clr_data[i]) && !xfer_done[i]) |=> req_stat[i]);

    a_r5_start_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      start_xfer[i] |-> (req_stat[i] && $past(frame_tick)));

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_xfer[i] |=> !start_xfer[i] || $past(frame_tick));

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[i] && !frame_tick) |=> !req_stat[i]);

    a_r8_refresh_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !int_en[i]) |=> buf_refresh[i]);

    a_r8_refresh_only_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> !buf_refresh[i]);
  end

endmodule

bind iso_dma_req iso_dma_req_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .int_en(int_en),
  .xfer_done(xfer_done), .clr_wr(clr_wr), .clr_data(clr_data),
  .req_stat(req_stat), .start_xfer(start_xfer), .buf_refresh(buf_refresh)
);

// File: tb/iso_dma_req_bench.sv
module iso_dma_req_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [N-1:0] int_en = '1, dma_en = '0, desc_valid = '0, xfer_done = '0, clr_data = '0;
  logic clr_wr = 1'b0;
  logic [N-1:0] req_stat, start_xfer, buf_refresh;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  iso_dma_req #(.NUM_EP(N)) u_iso_dma_req (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .int_en(int_en),
    .dma_en(dma_en), .desc_valid(desc_valid), .xfer_done(xfer_done),
    .clr_wr(clr_wr), .clr_data(clr_data), .req_stat(req_stat),
    .start_xfer(start_xfer), .buf_refresh(buf_refresh)
  );

  // {tick, int_en, dma_en, desc_valid, xfer_done, clr_wr, clr_data, exp_req, exp_start, exp_refresh}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 4'b1000, 4'b1111, 4'b0001, 4'b0000, 1'b0, 4'b0000, 4'b0111, 4'b0001, 4'b0111}, // R2 R3 R5
    {1'b0, 4'b1000, 4'b1111, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0111, 4'b0000, 4'b0000}, // R5 single pulse
    {1'b1, 4'b1000, 4'b1111, 4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b0111, 4'b0000, 4'b0111}, // R4 R8
    {1'b0, 4'b1000, 4'b1111, 4'b0000, 4'b0001, 1'b0, 4'b0000, 4'b0110, 4'b0000, 4'b0000}, // R5 done
    {1'b0, 4'b1000, 4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0010, 4'b0100, 4'b0000, 4'b0000}, // R6
    {1'b0, 4'b1000, 4'b1111, 4'b0000, 4'b0000, 1'b0, 4'b1111, 4'b0100, 4'b0000, 4'b0000}, // R6 no strobe
    {1'b1, 4'b1000, 4'b1111, 4'b0100, 4'b0000, 1'b1, 4'b0100, 4'b0111, 4'b0100, 4'b0111}, // R7
    {1'b1, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1000, 4'b1111}, // R2 R9
    {1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0011, 4'b1100, 4'b0000, 4'b0000}, // R6 R9
    {1'b1, 4'b0000, 4'b1110, 4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b0010, 4'b1111}, // R3 dma_en
    {1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b0001, 4'b0000, 4'b0000}, // R3 R5
    {1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0001, 4'b0000, 4'b0000}  // R3 hold
  };

  function automatic string row_tag(int r);
    case (r)
      0: return "R2/R3/R5 first tick";
      1: return "R5 pulse width";
      2: return "R4 no retrigger, R8";
      3: return "R5 completion";
      4: return "R6 clear one";
      5: return "R6 no write strobe";
      6: return "R7 clear with tick";
      7: return "R2/R9 mode switch";
      8: return "R6/R9 clear two";
      9: return "R3 dma disabled";
      10: return "R3/R5 done pulses";
      default: return "R3 latched hold";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [N-1:0] er, logic [N-1:0] es, logic [N-1:0] ef);
    chk(tag, "req_stat", req_stat, er);
    chk(tag, "start_xfer", start_xfer, es);
    chk(tag, "buf_refresh", buf_refresh, ef);
  endtask

  task automatic drive_idle();
    frame_tick = 1'b0; xfer_done = '0; clr_wr = 1'b0; clr_data = '0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", '0, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", '0, '0, '0);

    for (int r = 0; r < NV; r++) begin
      logic [33:0] v;
      v = VEC[r];
      frame_tick = v[33];
      int_en     = v[32:29];
      dma_en     = v[28:25];
      desc_valid = v[24:21];
      xfer_done  = v[20:17];
      clr_wr     = v[16];
      clr_data   = v[15:12];
      @(posedge clk);
      @(negedge clk);
      chk_all(row_tag(r), v[11:8], v[7:4], v[3:0]);
    end

    // R2: endpoints in interrupt mode are never raised
    drive_idle(); clr_wr = 1'b1; clr_data = '1;
    @(negedge clk);
    drive_idle(); int_en = '1; frame_tick = 1'b1; desc_valid = '1; dma_en = '1;
    @(negedge clk);
    chk_all("R2 interrupt mode ignored", '0, '0, '0);

    // R1: reset in mid-run clears raised requests
    drive_idle(); int_en = '0; frame_tick = 1'b1; desc_valid = '0;
    @(negedge clk);
    drive_idle();
    chk_all("R1 setup raise", '1, '0, '1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule